// File: doc/BRIEF.md
# Biphasic Stimulus Pulse Sequencer

This block turns a set of stimulation parameters into a timed sequence of 8-bit current codes for an electrical stimulator. The parameters (the two phase amplitudes, a rest level, the phase and gap durations, the spacing between pulses, the pulses per burst, the bursts per train, the inter-burst pause and a start delay) are written one at a time through an address/value write port. Writing the start register launches one train. A train is a start delay, then a number of bursts separated by inter-burst pauses, and each burst is a number of pulses separated by a spacing interval.

Each pulse drives the phase-1 amplitude. In biphasic mode, a gap at the rest level and then the phase-2 amplitude follow. A microsecond timebase is derived inside the block from the clock frequency parameter. Power and output-enable controls are mirrored to pins. Whenever either one is off, the current code is held at mid-scale (128, roughly zero current), while the timing still runs.

Top module: `stim_pulse_seq`

## Requirements
- R1: After reset, `busy` is 0, `cur_code` is 128, and `power_on` and `out_enable` are 0.
- R2: While a train runs, `cur_code` equals the phase-1 amplitude (address 2) in phase 1 and the phase-2 amplitude (address 3) in phase 2. During the start delay, the gap, the spacing and the inter-burst pause it equals the rest amplitude (address 15). Amplitudes take `wr_data[7:0]`.
- R3: One microsecond is CLK_HZ/1e6 clock cycles. Phase-1 duration (address 4), gap (address 5), phase-2 duration (address 6) and pulse spacing (address 7) count 10 µs units. Start delay (address 11) and inter-burst pause (address 9) count 1 µs units.
- R4: A programmed duration or count of 0 behaves as 1.
- R5: A train is ordered as: start delay, then bursts (count at address 10), each of N pulses (N at address 8). A spacing interval follows every pulse except the last of a burst. An inter-burst pause follows every burst except the last.
- R6: A write of 0 to address 1 selects monophasic pulses, in which the gap and phase 2 are skipped. Any nonzero value selects biphasic pulses.
- R7: Writing a nonzero value to address 12 while idle starts a train on the next cycle. `busy` stays high until the last phase of the last pulse ends. A start write while busy has no effect on the sequence.
- R8: `power_on` and `out_enable` mirror `wr_data[0]` written to addresses 13 and 14. While either is 0, `cur_code` is 128 and train timing is unchanged.
- R9: Any write to address 16 restores the defaults: biphasic 1, phase-1 amplitude 192, phase-2 amplitude 64, rest 128, all durations 1, spacing 1, inter-burst pause 1, pulses 1, bursts 1, delay 0, power 0, enable 0. Writes to address 0 or to addresses above 16 change nothing.
- R10: While idle with power and enable on, `cur_code` equals the rest amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write value |
| cur_code | output | 8 | Current command code, 128 is mid-scale |
| out_enable | output | 1 | Output enable; 0 means the output is shorted |
| power_on | output | 1 | Stimulator power control |
| busy | output | 1 | A train is in progress |

## Verification
The bench programs a small clock ratio of two cycles per microsecond. It compares every cycle of each train with a segment list that it builds from the written parameters.

- A monophasic train against a biphasic train shows whether the gap and phase 2 are skipped.
- Multi-pulse, multi-burst trains separate the spacing interval from the inter-burst pause and show when counting stops.
- An all-zero parameter set shows the clamp to one.
- A sweep over mode, pulse count and burst count covers the small configuration space.
- Trains with power or enable off, a start write in the middle of a train, and a run after a restore-defaults write preceded by writes to unmapped addresses cover the remaining rules.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int DUR_W = 16;
  localparam int CNT_W = 8;
  localparam int SEG_W = DUR_W + 4;
  localparam logic [7:0] MID_CODE = 8'd128;

  localparam int A_MODE   = 1;
  localparam int A_AMP1   = 2;
  localparam int A_AMP2   = 3;
  localparam int A_DUR1   = 4;
  localparam int A_GAP    = 5;
  localparam int A_DUR2   = 6;
  localparam int A_SPACE  = 7;
  localparam int A_NPULSE = 8;
  localparam int A_IBI    = 9;
  localparam int A_NBURST = 10;
  localparam int A_DELAY  = 11;
  localparam int A_START  = 12;
  localparam int A_POWER  = 13;
  localparam int A_ENABLE = 14;
  localparam int A_REST   = 15;
  localparam int A_DEFLT  = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DELAY, PH_ONE, PH_GAP, PH_TWO, PH_SPACE, PH_IBI
  } phase_e;

  typedef struct packed {
    logic             biphasic;
    logic [7:0]       amp1;
    logic [7:0]       amp2;
    logic [7:0]       rest;
    logic [DUR_W-1:0] dur1;
    logic [DUR_W-1:0] gap;
    logic [DUR_W-1:0] dur2;
    logic [DUR_W-1:0] space;
    logic [DUR_W-1:0] ibi;
    logic [DUR_W-1:0] delay;
    logic [CNT_W-1:0] npulse;
    logic [CNT_W-1:0] nburst;
    logic             power;
    logic             enable;
  } stim_cfg_t;

  function automatic stim_cfg_t default_cfg();
    stim_cfg_t c;
    c.biphasic = 1'b1;
    c.amp1     = 8'd192;
    c.amp2     = 8'd64;
    c.rest     = MID_CODE;
    c.dur1     = DUR_W'(1);
    c.gap      = DUR_W'(1);
    c.dur2     = DUR_W'(1);
    c.space    = DUR_W'(1);
    c.ibi      = DUR_W'(1);
    c.delay    = '0;
    c.npulse   = CNT_W'(1);
    c.nburst   = CNT_W'(1);
    c.power    = 1'b0;
    c.enable   = 1'b0;
    return c;
  endfunction

  // Segment length in microseconds; a zero count is treated as one.
  function automatic logic [SEG_W-1:0] seg_units(input logic [DUR_W-1:0] v,
                                                 input logic tens);
    logic [SEG_W-1:0] b;
    b = (v == '0) ? SEG_W'(1) : SEG_W'(v);
    return tens ? b * SEG_W'(10) : b;
  endfunction

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/stim_tick.sv
module stim_tick #(
  parameter int CYC_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_prescale
      logic [PW-1:0] cnt;
      assign tick = run && (cnt == PW'(CYC_PER_US - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/stim_regs.sv
module stim_regs
  import stim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output stim_cfg_t         cfg,
  output logic              start_wr
);
  assign start_wr = wr_en && (wr_addr == ADDR_W'(A_START)) && (wr_data != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= default_cfg();
    end else if (wr_en) begin
      case (int'(wr_addr))
        A_MODE:   cfg.biphasic <= (wr_data != '0);
        A_AMP1:   cfg.amp1     <= wr_data[7:0];
        A_AMP2:   cfg.amp2     <= wr_data[7:0];
        A_REST:   cfg.rest     <= wr_data[7:0];
        A_DUR1:   cfg.dur1     <= DUR_W'(wr_data);
        A_GAP:    cfg.gap      <= DUR_W'(wr_data);
        A_DUR2:   cfg.dur2     <= DUR_W'(wr_data);
        A_SPACE:  cfg.space    <= DUR_W'(wr_data);
        A_IBI:    cfg.ibi      <= DUR_W'(wr_data);
        A_DELAY:  cfg.delay    <= DUR_W'(wr_data);
        A_NPULSE: cfg.npulse   <= CNT_W'(wr_data);
        A_NBURST: cfg.nburst   <= CNT_W'(wr_data);
        A_POWER:  cfg.power    <= wr_data[0];
        A_ENABLE: cfg.enable   <= wr_data[0];
        A_DEFLT:  cfg          <= default_cfg();
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/stim_seq.sv
module stim_seq
  import stim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stim_cfg_t cfg,
  input  logic      start_wr,
  input  logic      tick,
  output phase_e    phase,
  output logic      seg_done,
  output logic      start_take,
  output logic      train_end
);
  logic [SEG_W-1:0] rem, nxt_rem;
  logic [CNT_W-1:0] pidx, bidx;
  phase_e           nxt_phase;
  logic             pulse_end, go_space, go_ibi, last_pulse, last_burst;

  assign seg_done   = tick && (phase != PH_IDLE) && (rem == SEG_W'(1));
  assign start_take = (phase == PH_IDLE) && start_wr;
  assign last_pulse = ({1'b0, pidx} + (CNT_W+1)'(1)) >= {1'b0, at_least_one(cfg.npulse)};
  assign last_burst = ({1'b0, bidx} + (CNT_W+1)'(1)) >= {1'b0, at_least_one(cfg.nburst)};

  always_comb begin
    nxt_phase = phase;
    nxt_rem   = rem;
    pulse_end = 1'b0;
    go_space  = 1'b0;
    go_ibi    = 1'b0;
    train_end = 1'b0;
    if (start_take) begin
      nxt_phase = PH_DELAY;
      nxt_rem   = seg_units(cfg.delay, 1'b0);
    end else if (tick && phase != PH_IDLE && !seg_done) begin
      nxt_rem = rem - SEG_W'(1);
    end else if (seg_done) begin
      case (phase)
        PH_DELAY, PH_SPACE, PH_IBI: begin
          nxt_phase = PH_ONE;
          nxt_rem   = seg_units(cfg.dur1, 1'b1);
        end
        PH_ONE: begin
          if (cfg.biphasic) begin
            nxt_phase = PH_GAP;
            nxt_rem   = seg_units(cfg.gap, 1'b1);
          end else begin
            pulse_end = 1'b1;
          end
        end
        PH_GAP: begin
          nxt_phase = PH_TWO;
          nxt_rem   = seg_units(cfg.dur2, 1'b1);
        end
        PH_TWO:  pulse_end = 1'b1;
        default: ;
      endcase
      if (pulse_end) begin
        if (!last_pulse) begin
          go_space  = 1'b1;
          nxt_phase = PH_SPACE;
          nxt_rem   = seg_units(cfg.space, 1'b1);
        end else if (!last_burst) begin
          go_ibi    = 1'b1;
          nxt_phase = PH_IBI;
          nxt_rem   = seg_units(cfg.ibi, 1'b0);
        end else begin
          train_end = 1'b1;
          nxt_phase = PH_IDLE;
          nxt_rem   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      rem   <= '0;
      pidx  <= '0;
      bidx  <= '0;
    end else begin
      phase <= nxt_phase;
      rem   <= nxt_rem;
      if (start_take) begin
        pidx <= '0;
        bidx <= '0;
      end else if (go_space) begin
        pidx <= pidx + CNT_W'(1);
      end else if (go_ibi) begin
        pidx <= '0;
        bidx <= bidx + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/stim_pulse_seq.sv
module stim_pulse_seq
  import stim_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        cur_code,
  output logic              out_enable,
  output logic              power_on,
  output logic              busy
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

  stim_cfg_t cfg;
  phase_e    phase;
  logic      start_wr, tick, seg_done, start_take, train_end;

  stim_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .start_wr(start_wr)
  );

  stim_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  stim_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .start_wr(start_wr), .tick(tick),
    .phase(phase), .seg_done(seg_done), .start_take(start_take),
    .train_end(train_end)
  );

  assign busy       = (phase != PH_IDLE);
  assign power_on   = cfg.power;
  assign out_enable = cfg.enable;

  always_comb begin
    if (!(cfg.power && cfg.enable)) cur_code = MID_CODE;
    else if (phase == PH_ONE)       cur_code = cfg.amp1;
    else if (phase == PH_TWO)       cur_code = cfg.amp2;
    else                            cur_code = cfg.rest;
  end
endmodule

// File: rtl/stim_pulse_seq_chk.sv
module stim_pulse_seq_chk
  import stim_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [7:0] cur_code,
  input logic       out_enable,
  input logic       power_on,
  input logic       start_wr,
  input logic       tick,
  input logic       seg_done,
  input logic       train_end,
  input phase_e     phase,
  input stim_cfg_t  cfg
);
  p_mid_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(power_on && out_enable) |-> cur_code == MID_CODE);

  p_idle_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && power_on && out_enable) |-> cur_code == cfg.rest);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !busy) |=> (busy && phase == PH_DELAY));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(phase));

  p_no_redelay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_DELAY) |=> phase != PH_DELAY);

  p_mono_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ONE && seg_done && !cfg.biphasic) |=> phase != PH_GAP);

  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    train_end |=> !busy);
endmodule

bind stim_pulse_seq stim_pulse_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cur_code(cur_code),
  .out_enable(out_enable), .power_on(power_on), .start_wr(start_wr),
  .tick(tick), .seg_done(seg_done), .train_end(train_end),
  .phase(phase), .cfg(cfg)
);

// File: tb/stim_pulse_seq_bench.sv
module stim_pulse_seq_bench;
  localparam int CLK_HZ = 2_000_000;
  localparam int CPU    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  cur_code;
  logic        out_enable, power_on, busy;

  stim_pulse_seq #(.CLK_HZ(CLK_HZ)) u_stim_pulse_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cur_code(cur_code), .out_enable(out_enable),
    .power_on(power_on), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  int m_bi, m_a1, m_a2, m_rest, m_p1, m_gap, m_p2, m_sp, m_ibi, m_dly;
  int m_np, m_nb, m_pwr, m_en;
  int seg_code[0:511];
  int seg_len[0:511];
  int nseg;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_defaults();
    m_bi = 1; m_a1 = 192; m_a2 = 64; m_rest = 128;
    m_p1 = 1; m_gap = 1; m_p2 = 1; m_sp = 1; m_ibi = 1; m_dly = 0;
    m_np = 1; m_nb = 1; m_pwr = 0; m_en = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      1:  m_bi   = (d != 0);
      2:  m_a1   = d & 255;
      3:  m_a2   = d & 255;
      4:  m_p1   = d;
      5:  m_gap  = d;
      6:  m_p2   = d;
      7:  m_sp   = d;
      8:  m_np   = d;
      9:  m_ibi  = d;
      10: m_nb   = d;
      11: m_dly  = d;
      13: m_pwr  = d & 1;
      14: m_en   = d & 1;
      15: m_rest = d & 255;
      16: model_defaults();
      default: ;
    endcase
  endtask

  function automatic int mn1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int shown(input int c);
    return (m_pwr != 0 && m_en != 0) ? c : 128;
  endfunction

  task automatic add_seg(input int c, input int l);
    seg_code[nseg] = c;
    seg_len[nseg]  = l;
    nseg++;
  endtask

  task automatic build();
    nseg = 0;
    add_seg(m_rest, mn1(m_dly) * CPU);
    for (int b = 0; b < mn1(m_nb); b++) begin
      for (int p = 0; p < mn1(m_np); p++) begin
        add_seg(m_a1, 10 * mn1(m_p1) * CPU);
        if (m_bi != 0) begin
          add_seg(m_rest, 10 * mn1(m_gap) * CPU);
          add_seg(m_a2, 10 * mn1(m_p2) * CPU);
        end
        if (p < mn1(m_np) - 1) add_seg(m_rest, 10 * mn1(m_sp) * CPU);
      end
      if (b < mn1(m_nb) - 1) add_seg(m_rest, mn1(m_ibi) * CPU);
    end
  endtask

  // Starts one train and compares every cycle; retrig_at >= 0 issues a start write mid-train.
  task automatic run_train(input string req, input int retrig_at);
    int seg, pos, total;
    build();
    total = 0;
    for (int i = 0; i < nseg; i++) total += seg_len[i];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd12; wr_data = 16'd1;
    @(negedge clk);
    wr_en = 1'b0;
    seg = 0; pos = 0;
    for (int j = 0; j < total; j++) begin
      check(cur_code == 8'(shown(seg_code[seg])), req, int'(cur_code), shown(seg_code[seg]));
      check(busy == 1'b1, "R7 busy during train", int'(busy), 1);
      if (j == retrig_at) begin
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 16'd1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      pos++;
      if (pos == seg_len[seg]) begin
        seg++;
        pos = 0;
      end
    end
    wr_en = 1'b0;
    check(busy == 1'b0, "R7 busy low after train", int'(busy), 0);
    check(cur_code == 8'(shown(m_rest)), "R10 idle code after train", int'(cur_code), shown(m_rest));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(cur_code == 8'd128, "R1 code", int'(cur_code), 128);
    check(power_on == 1'b0, "R1 power", int'(power_on), 0);
    check(out_enable == 1'b0, "R1 enable", int'(out_enable), 0);

    // R8 mirrors, R10 idle rest
    wr(13, 1);
    wr(14, 1);
    check(power_on == 1'b1, "R8 power mirror", int'(power_on), 1);
    check(out_enable == 1'b1, "R8 enable mirror", int'(out_enable), 1);
    wr(15, 100);
    check(cur_code == 8'd100, "R10 idle rest", int'(cur_code), 100);

    // R6 monophasic, R2 amplitude, R3 units
    wr(1, 0); wr(2, 200); wr(4, 2); wr(11, 3);
    run_train("R6 R3 monophasic train", -1);

    // R5 biphasic multi-pulse multi-burst, R2 phase-2 amplitude
    wr(1, 1); wr(3, 50); wr(5, 1); wr(6, 1); wr(7, 2); wr(8, 3); wr(10, 2); wr(9, 5);
    run_train("R5 R2 biphasic bursts", -1);

    // R7 start write mid-train is ignored
    run_train("R7 retrigger ignored", 10);

    // R4 zero counts act as one
    wr(11, 0); wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0); wr(9, 0); wr(8, 0); wr(10, 0);
    run_train("R4 zero clamp", -1);

    // Sweep over mode, pulse count and burst count (R5 R6)
    wr(4, 1); wr(7, 1); wr(9, 3); wr(11, 2);
    for (int bi = 0; bi < 2; bi++)
      for (int np = 1; np <= 3; np++)
        for (int nb = 1; nb <= 2; nb++) begin
          wr(1, bi); wr(8, np); wr(10, nb);
          run_train("R5 R6 sweep", -1);
        end

    // R8 enable off, then power off: code mid-scale, timing unchanged
    wr(14, 0);
    check(cur_code == 8'd128, "R8 idle enable off", int'(cur_code), 128);
    run_train("R8 enable off", -1);
    wr(14, 1); wr(13, 0);
    run_train("R8 power off", -1);

    // R9 ignored addresses, then restore defaults
    wr(13, 1);
    wr(0, 77);
    wr(20, 5);
    wr(31, 9);
    run_train("R9 unmapped writes ignored", -1);
    wr(16, 1);
    check(power_on == 1'b0, "R9 default power", int'(power_on), 0);
    check(out_enable == 1'b0, "R9 default enable", int'(out_enable), 0);
    wr(13, 1); wr(14, 1);
    check(cur_code == 8'd128, "R9 default rest", int'(cur_code), 128);
    run_train("R9 default train", -1);

    finish_run();
  end
endmodule